// File: doc/BRIEF.md
# Machine-mode trap controller

This block holds the machine-level trap state of a small processor core: the trap vector (handler base and mode), the saved exception PC, the cause and the trap value. While an instruction is in flight it collects fault strobes from fetch, decode, the load/store path and the register/CSR access checks, and keeps the first one in a pending register. When the instruction retires with a fault pending, the block redirects the PC to the handler instead of the sequential next address. A trap-return strobe sends the PC back to the saved exception PC.

The block also cleans up after faults so that the faulting instruction completes harmlessly. A fetch outside memory is replaced by the no-op word, an out-of-range load returns zero, and an out-of-range store is blocked. Until software has written the trap vector at least once there is no handler. A trap in that state raises a sticky halt and does not redirect.

Top module: `trap_unit`

## Requirements
- R1: After reset, the trap vector (CSR 0x305), saved PC (0x341), cause (0x342) and trap value (0x343) all read as zero. redirect_o and halt_o are low, and the handler counts as not configured.
- R2: A write to CSR 0x305 stores bits [1:0] as the mode and the rest, with bits [1:0] cleared, as the handler base. Reading it back returns base OR mode. Any write marks the handler as configured.
- R3: In mode 0, 2 or 3, a trap redirects to the handler base itself.
- R4: In mode 1, a trap redirects to the base plus four times the cause code.
- R5: A trap is taken in the cycle retire_i is high. In that same cycle redirect_o is high. In the next cycle the cause register holds the cause code, the saved PC holds pc_i, and the trap value is zero.
- R6: The cause codes are 0 for a misaligned fetch, 1 for a fetch access fault, 2 for an illegal instruction, 3 for a breakpoint, 5 for a load access fault and 7 for a store access fault.
- R7: Faults reported before retirement are held until retire_i, and redirect_o stays low while retire_i is low. insn_start_i discards any fault left pending from an earlier instruction.
- R8: Within one instruction the first fault captured is kept, and later faults are ignored. Among strobes raised in the same cycle, the lowest cause code wins, so a fetch fault beats every fault that follows it.
- R9: With fetch_oob_i high, fetch_insn_o is 0x00000013. With ld_oob_i high, ld_data_o is zero. With st_oob_i high, st_en_o is low.
- R10: An illegal-instruction fault (code 2) is raised by a CSR access to an address other than the four above. It is also raised by a register access with index 16 or above while rf_reduced_i is high. The same register index with rf_reduced_i low raises no fault.
- R11: ret_i at retirement with no fault pending redirects to the saved PC.
- R12: A trap while the handler is not configured raises halt_o and does not redirect. The halt holds until reset, and the trap registers are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | PC of the instruction in flight |
| insn_start_i | input | 1 | First cycle of an instruction |
| retire_i | input | 1 | Instruction completes this cycle |
| ret_i | input | 1 | Instruction is a trap return |
| fetch_insn_i | input | XLEN | Word from instruction memory |
| fetch_misal_i | input | 1 | Fetch address misaligned |
| fetch_oob_i | input | 1 | Fetch address outside memory |
| fetch_insn_o | output | XLEN | Instruction word passed to decode |
| ill_i | input | 1 | Decoder found an undefined encoding |
| brk_i | input | 1 | Breakpoint instruction |
| rf_acc_i | input | 1 | Register file access |
| rf_idx_i | input | 5 | Register index accessed |
| rf_reduced_i | input | 1 | Only 16 registers enabled |
| ld_data_i | input | XLEN | Load data from memory |
| ld_oob_i | input | 1 | Load address outside memory |
| ld_data_o | output | XLEN | Load data to the core |
| st_req_i | input | 1 | Store request |
| st_oob_i | input | 1 | Store address outside memory |
| st_en_o | output | 1 | Store enable to memory |
| csr_re_i | input | 1 | CSR read access |
| csr_we_i | input | 1 | CSR write access |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| redirect_o | output | 1 | Take redir_pc_o as next PC |
| redir_pc_o | output | XLEN | Redirect target |
| halt_o | output | 1 | Core halted by an unhandled trap |

## Verification
The hardest case to reach is a fault that arrives in one cycle of an instruction and a second, different fault that arrives in a later cycle of the same instruction. The retirement must report only the first. The random stimulus spreads fault strobes over the start cycle and two middle cycles, which produces these orderings often and in every mode. Directed cases add an abandoned instruction whose fault must not carry over, and the halt taken before any handler exists.

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int XLEN = 32,
  parameter int CW = 5,
  parameter logic [11:0] A_VEC = 12'h305,
  parameter logic [11:0] A_EPC = 12'h341,
  parameter logic [11:0] A_CAUSE = 12'h342,
  parameter logic [11:0] A_TVAL = 12'h343
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_i,
  input  logic            insn_start_i,
  input  logic            retire_i,
  input  logic            ret_i,
  input  logic [XLEN-1:0] fetch_insn_i,
  input  logic            fetch_misal_i,
  input  logic            fetch_oob_i,
  output logic [XLEN-1:0] fetch_insn_o,
  input  logic            ill_i,
  input  logic            brk_i,
  input  logic            rf_acc_i,
  input  logic [4:0]      rf_idx_i,
  input  logic            rf_reduced_i,
  input  logic [XLEN-1:0] ld_data_i,
  input  logic            ld_oob_i,
  output logic [XLEN-1:0] ld_data_o,
  input  logic            st_req_i,
  input  logic            st_oob_i,
  output logic            st_en_o,
  input  logic            csr_re_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redir_pc_o,
  output logic            halt_o
);
  localparam logic [XLEN-1:0] NOP = XLEN'(32'h13);
  localparam logic [CW-1:0] C_IMIS = CW'(0), C_IACC = CW'(1), C_ILL = CW'(2),
                            C_BRK = CW'(3), C_LACC = CW'(5), C_SACC = CW'(7);

  logic [XLEN-1:0] base_q, epc_q, tval_q;
  logic [1:0]      mode_q;
  logic [CW-1:0]   cause_q, pend_c, req_c, eff_c;
  logic            cfg_q, pend_v, halt_q;
  logic            csr_known, illegal, req_v, eff_v, trap_go, ret_go;

  assign fetch_insn_o = fetch_oob_i ? NOP : fetch_insn_i;
  assign ld_data_o    = ld_oob_i ? '0 : ld_data_i;
  assign st_en_o      = st_req_i & ~st_oob_i;

  assign csr_known = (csr_addr_i == A_VEC) || (csr_addr_i == A_EPC) ||
                     (csr_addr_i == A_CAUSE) || (csr_addr_i == A_TVAL);
  assign illegal = ill_i | ((csr_re_i | csr_we_i) & ~csr_known) |
                   (rf_acc_i & rf_reduced_i & rf_idx_i[4]);

  always_comb begin
    req_v = 1'b1;
    if (fetch_misal_i)    req_c = C_IMIS;
    else if (fetch_oob_i) req_c = C_IACC;
    else if (illegal)     req_c = C_ILL;
    else if (brk_i)       req_c = C_BRK;
    else if (ld_oob_i)    req_c = C_LACC;
    else if (st_oob_i)    req_c = C_SACC;
    else begin
      req_v = 1'b0;
      req_c = '0;
    end
  end

  wire keep = pend_v & ~insn_start_i;
  assign eff_v = keep | req_v;
  assign eff_c = keep ? pend_c : req_c;

  assign trap_go = retire_i & eff_v & ~halt_q;
  assign ret_go  = retire_i & ret_i & ~eff_v & ~halt_q;

  wire [XLEN-1:0] vec_pc = base_q + (XLEN'(eff_c) << 2);
  assign redirect_o = (trap_go & cfg_q) | ret_go;
  assign redir_pc_o = trap_go ? ((mode_q == 2'd1) ? vec_pc : base_q) : epc_q;
  assign halt_o     = halt_q | (trap_go & ~cfg_q);

  always_comb begin
    case (csr_addr_i)
      A_VEC:   csr_rdata_o = base_q | XLEN'(mode_q);
      A_EPC:   csr_rdata_o = epc_q;
      A_CAUSE: csr_rdata_o = XLEN'(cause_q);
      A_TVAL:  csr_rdata_o = tval_q;
      default: csr_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      mode_q  <= '0;
      cfg_q   <= 1'b0;
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
      pend_v  <= 1'b0;
      pend_c  <= '0;
      halt_q  <= 1'b0;
    end else begin
      if (csr_we_i && csr_addr_i == A_VEC) begin
        mode_q <= csr_wdata_i[1:0];
        base_q <= {csr_wdata_i[XLEN-1:2], 2'b00};
        cfg_q  <= 1'b1;
      end
      if (trap_go) begin
        epc_q   <= pc_i;
        cause_q <= eff_c;
        tval_q  <= '0;
        if (!cfg_q) halt_q <= 1'b1;
      end else if (csr_we_i) begin
        if (csr_addr_i == A_EPC)   epc_q   <= csr_wdata_i;
        if (csr_addr_i == A_CAUSE) cause_q <= csr_wdata_i[CW-1:0];
        if (csr_addr_i == A_TVAL)  tval_q  <= csr_wdata_i;
      end
      pend_v <= retire_i ? 1'b0 : eff_v;
      pend_c <= retire_i ? '0 : eff_c;
    end
  end

  AST_CAUSE_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> cause_q == $past(eff_c)); // R5
  AST_EPC_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> epc_q == $past(pc_i)); // R5
  AST_TVAL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_go |=> tval_q == '0); // R5
  AST_NOREDIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |-> !redirect_o); // R7
  AST_NO_REDIR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !redirect_o); // R12
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q); // R12
  AST_NOP_INJ: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_oob_i |-> fetch_insn_o == NOP); // R9
  AST_STORE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    st_oob_i |-> !st_en_o); // R9
  AST_RET_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |-> redirect_o && redir_pc_o == epc_q); // R11
endmodule

// File: tb/sim_trap_unit.sv
module sim_trap_unit;
  logic clk = 0, rst_n = 0;
  logic [31:0] pc_i = 0, fetch_insn_i = 0, ld_data_i = 0, csr_wdata_i = 0;
  logic insn_start_i = 0, retire_i = 0, ret_i = 0, fetch_misal_i = 0, fetch_oob_i = 0;
  logic ill_i = 0, brk_i = 0, rf_acc_i = 0, rf_reduced_i = 0, ld_oob_i = 0;
  logic st_req_i = 0, st_oob_i = 0, csr_re_i = 0, csr_we_i = 0;
  logic [4:0] rf_idx_i = 0;
  logic [11:0] csr_addr_i = 0;
  logic [31:0] fetch_insn_o, ld_data_o, csr_rdata_o, redir_pc_o;
  logic st_en_o, redirect_o, halt_o;

  trap_unit u0 (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  logic m_cfg; logic [31:0] m_base, m_epc; logic [1:0] m_mode;

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] prio(input logic [5:0] f);
    if (f[0]) return 0;
    if (f[1]) return 1;
    if (f[2]) return 2;
    if (f[3]) return 3;
    if (f[4]) return 5;
    return 7;
  endfunction

  function automatic logic [31:0] tgt(input logic [4:0] c);
    return (m_mode == 2'd1) ? m_base + {25'd0, c, 2'b00} : m_base;
  endfunction

  task automatic clr();
    insn_start_i = 0; retire_i = 0; ret_i = 0; fetch_misal_i = 0; fetch_oob_i = 0;
    ill_i = 0; brk_i = 0; rf_acc_i = 0; ld_oob_i = 0; st_oob_i = 0;
    csr_re_i = 0; csr_we_i = 0;
  endtask

  task automatic set_f(input logic [5:0] f);
    fetch_misal_i = f[0]; fetch_oob_i = f[1]; ill_i = f[2];
    brk_i = f[3]; ld_oob_i = f[4]; st_oob_i = f[5];
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); clr(); csr_re_i = 1; csr_addr_i = a; #1 v = csr_rdata_o;
  endtask

  task automatic wr_vec(input logic [31:0] v);
    @(negedge clk); clr(); csr_we_i = 1; csr_addr_i = 12'h305; csr_wdata_i = v;
    m_cfg = 1; m_mode = v[1:0]; m_base = {v[31:2], 2'b00};
    @(negedge clk); clr();
  endtask

  task automatic do_reset();
    @(negedge clk); clr(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_cfg = 0; m_base = 0; m_mode = 0; m_epc = 0;
  endtask

  // start faults f0, mid faults f1 then f2; retire with ret
  task automatic run_insn(input logic [31:0] pc, input logic [5:0] f0, input logic [5:0] f1,
                          input logic [5:0] f2, input logic ret, input string req);
    logic [4:0] c; logic any; logic [31:0] v;
    any = (f0 != 0) || (f1 != 0) || (f2 != 0);
    c = (f0 != 0) ? prio(f0) : (f1 != 0) ? prio(f1) : prio(f2);
    @(negedge clk); clr(); pc_i = pc; insn_start_i = 1; set_f(f0);
    @(negedge clk); clr(); set_f(f1); #1
    chk(!redirect_o, "R7", {31'd0, redirect_o}, 0);
    @(negedge clk); clr(); set_f(f2);
    @(negedge clk); clr(); retire_i = 1; ret_i = ret; #1
    if (any) begin
      chk(redirect_o == m_cfg, "R5", {31'd0, redirect_o}, {31'd0, m_cfg});
      if (m_cfg) chk(redir_pc_o == tgt(c), (m_mode == 1) ? "R4" : "R3", redir_pc_o, tgt(c));
      else chk(halt_o, "R12", {31'd0, halt_o}, 1);
    end else if (ret) begin
      chk(redirect_o && redir_pc_o == m_epc, "R11", redir_pc_o, m_epc);
    end else begin
      chk(!redirect_o, "R7", {31'd0, redirect_o}, 0);
    end
    if (any) begin
      m_epc = pc;
      csr_rd(12'h342, v); chk(v == {27'd0, c}, $sformatf("R6 %s", req), v, {27'd0, c});
      csr_rd(12'h341, v); chk(v == pc, "R5", v, pc);
      csr_rd(12'h343, v); chk(v == 0, "R5", v, 0);
    end
  endtask

  initial begin
    logic [31:0] v, r;
    r = $urandom(32'h5eed);
    do_reset();
    // R1
    foreach (u0.A_VEC[i]) ;
    csr_rd(12'h305, v); chk(v == 0, "R1", v, 0);
    csr_rd(12'h341, v); chk(v == 0, "R1", v, 0);
    csr_rd(12'h342, v); chk(v == 0, "R1", v, 0);
    csr_rd(12'h343, v); chk(v == 0, "R1", v, 0);
    chk(!halt_o && !redirect_o, "R1", {30'd0, halt_o, redirect_o}, 0);
    // R12 unconfigured halt
    run_insn(32'h100, 6'b000100, 0, 0, 0, "R12");
    repeat (3) @(negedge clk);
    chk(halt_o, "R12 sticky", {31'd0, halt_o}, 1);
    do_reset();
    // R2
    wr_vec(32'h0000_2003);
    csr_rd(12'h305, v); chk(v == 32'h2003, "R2", v, 32'h2003);
    // R3 mode 3 direct, fetch misaligned cause 0
    run_insn(32'h40, 6'b000001, 0, 0, 0, "misaligned fetch");
    // R4 vectored
    wr_vec(32'h0000_8001);
    run_insn(32'h44, 6'b000010, 0, 0, 0, "fetch access");
    run_insn(32'h48, 0, 6'b000100, 0, 0, "illegal");
    run_insn(32'h4c, 0, 6'b001000, 0, 0, "breakpoint");
    run_insn(32'h50, 0, 6'b010000, 0, 0, "load access");
    run_insn(32'h54, 0, 6'b100000, 0, 0, "store access");
    // R8 first kept, fetch beats later
    run_insn(32'h58, 0, 6'b100000, 6'b000100, 0, "R8 first kept");
    run_insn(32'h5c, 6'b000010, 6'b000100, 0, 0, "R8 fetch first");
    run_insn(32'h60, 0, 6'b110100, 0, 0, "R8 same cycle");
    // R11 return
    run_insn(32'h64, 0, 0, 0, 1, "R11");
    // R7 abandoned instruction does not carry its fault
    @(negedge clk); clr(); pc_i = 32'h70; insn_start_i = 1;
    @(negedge clk); clr(); ill_i = 1;
    @(negedge clk); clr(); insn_start_i = 1;
    @(negedge clk); clr(); retire_i = 1; #1
    chk(!redirect_o, "R7 start clears", {31'd0, redirect_o}, 0);
    // R10 unknown CSR and reduced register set
    @(negedge clk); clr(); pc_i = 32'h80; insn_start_i = 1;
    @(negedge clk); clr(); csr_re_i = 1; csr_addr_i = 12'h7c0;
    @(negedge clk); clr(); retire_i = 1; #1
    chk(redirect_o && redir_pc_o == m_base + 8, "R10 csr", redir_pc_o, m_base + 8);
    @(negedge clk); clr(); pc_i = 32'h84; insn_start_i = 1;
    @(negedge clk); clr(); rf_acc_i = 1; rf_idx_i = 17; rf_reduced_i = 1;
    @(negedge clk); clr(); rf_reduced_i = 0; retire_i = 1; #1
    chk(redirect_o && redir_pc_o == m_base + 8, "R10 reg", redir_pc_o, m_base + 8);
    @(negedge clk); clr(); pc_i = 32'h88; insn_start_i = 1;
    @(negedge clk); clr(); rf_acc_i = 1; rf_idx_i = 17; rf_reduced_i = 0;
    @(negedge clk); clr(); retire_i = 1; #1
    chk(!redirect_o, "R10 full set", {31'd0, redirect_o}, 0);
    m_epc = 32'h84;
    // R9 cleanup paths
    @(negedge clk); clr(); fetch_insn_i = 32'hdeadbeef; fetch_oob_i = 1; #1
    chk(fetch_insn_o == 32'h13, "R9 nop", fetch_insn_o, 32'h13);
    fetch_oob_i = 0; #1 chk(fetch_insn_o == 32'hdeadbeef, "R9 pass", fetch_insn_o, 32'hdeadbeef);
    ld_data_i = 32'h1234; ld_oob_i = 1; #1 chk(ld_data_o == 0, "R9 load", ld_data_o, 0);
    st_req_i = 1; st_oob_i = 1; #1 chk(!st_en_o, "R9 store", {31'd0, st_en_o}, 0);
    st_oob_i = 0; #1 chk(st_en_o, "R9 store ok", {31'd0, st_en_o}, 1);
    st_req_i = 0; clr();
    // random
    for (int i = 0; i < 300; i++) begin
      logic [5:0] f0, f1, f2;
      if ($urandom % 8 == 0) wr_vec({$urandom} & 32'h0fff_fffc | ($urandom % 4));
      f0 = ($urandom % 4 == 0) ? 6'($urandom % 4) : 6'd0;
      f1 = ($urandom % 2 == 0) ? 6'($urandom & 6'h3c) : 6'd0;
      f2 = ($urandom % 2 == 0) ? 6'($urandom & 6'h3c) : 6'd0;
      run_insn({$urandom} & ~32'h1, f0, f1, f2, 1'($urandom % 3 == 0), "random");
      chk(!halt_o, "R12 configured", {31'd0, halt_o}, 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule